// File: doc/BRIEF.md
# Dual-Channel Pseudo-Random Self-Test Controller

This block checks the digital half of a two-channel sampled-data path without needing the analog converter. An accepted start substitutes pseudo-random words for the converter samples of each selected channel, right where those samples enter the downstream logic. The words stay visible on the channel outputs for the whole run. Whatever the downstream path sends back is compressed, one word per sample clock, into a 16-bit signature. After a fixed run of 512 samples the block stops by itself, raises a done flag and publishes one signature as a low byte and a high byte.

Each run can either continue the pseudo-random sequence from where the last run left it or reload the seed. Each channel also has a hold input that pins its generator to the seed. When both channels are tested together, the published signature belongs to channel A.

Top module: `pn_bist_ctrl`

## Requirements
- R1: After reset, `done` is 0, `sig_lo` and `sig_hi` are 0, and each channel output equals its converter input.
- R2: A run is accepted at the first clock edge that sees `run_start` at 1 after it was 0, while no run is active and `chan_sel` is not 2'b00. Bit 0 of `chan_sel` selects channel A and bit 1 selects channel B. From the cycle after acceptance, each selected channel outputs bits [22:9] of a 23-bit shift register. The register advances once per cycle by shifting left and inserting bit22 XOR bit17 at bit 0.
- R3: A channel not selected for the current run, and every channel outside a run, passes its converter input straight to its output.
- R4: A run outputs exactly 512 words. `done` rises in the cycle after the last word, stays 0 during the run, and stays 1 until the next accepted start.
- R5: Each selected channel keeps a 16-bit signature. It is cleared at acceptance and updated on every run cycle as m' = (m<<1) XOR (m[15] ? 16'h1021 : 0) XOR the returned 14-bit word zero-extended. This gives 512 updates per run.
- R6: The published signature is channel A's when `chan_sel` is 2'b01 or 2'b11, and channel B's when it is 2'b10. Its bits [7:0] appear on `sig_lo` and its bits [15:8] on `sig_hi`.
- R7: With `resume_pn` at 1 at acceptance, a channel's sequence continues from its last state. With `resume_pn` at 0, both generators reload the all-ones seed.
- R8: While `pn_hold` bit i is 1, generator i is held at the seed, so a selected channel outputs 14'h3FFF for the whole run.
- R9: A start edge during a run has no effect on the words, the run length or the result. A start with `chan_sel` at 2'b00 starts no run: `done`, the signature and the outputs do not change.
- R10: `sig_lo` and `sig_hi` keep the previous result throughout a run. They change only in the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_sel | input | 2 | Channels to test (bit 0 = A, bit 1 = B), latched at start |
| run_start | input | 1 | Start request; its rising edge starts a run |
| resume_pn | input | 1 | 1 = continue the sequence, 0 = reload the seed at start |
| pn_hold | input | 2 | Per-channel hold of the generator at the seed |
| adc_a | input | 14 | Converter sample, channel A |
| adc_b | input | 14 | Converter sample, channel B |
| path_out_a | output | 14 | Data into the digital path, channel A |
| path_out_b | output | 14 | Data into the digital path, channel B |
| ret_a | input | 14 | Word returned by the digital path, channel A |
| ret_b | input | 14 | Word returned by the digital path, channel B |
| sig_lo | output | 8 | Signature bits [7:0] |
| sig_hi | output | 8 | Signature bits [15:8] |
| done | output | 1 | Run finished |

## Verification
The return ports are looped back through a different transform on each channel, so a signature computed from the wrong channel or from an untransformed word gives a different value. Runs are made with A alone, B alone and both channels. They alternate seed reload and continuation, so a generator that restarts when it should resume, or advances while unselected, produces a different word stream. A held generator gives a constant stream that separates hold from seed reload. A mid-run start pulse and a start with no channel selected show whether stray starts are ignored.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int DATA_W   = 14;
  localparam int PN_W     = 23;
  localparam int PN_TAP   = 18;
  localparam int SIG_W    = 16;
  localparam int RUN_LEN  = 512;
  localparam int CHANNELS = 2;
  localparam logic [PN_W-1:0]  PN_SEED   = '1;
  localparam logic [SIG_W-1:0] MISR_POLY = 16'h1021;

  function automatic logic [PN_W-1:0] lfsr_next(input logic [PN_W-1:0] s);
    logic fb;
    fb = s[PN_W-1] ^ s[PN_TAP-1];
    return {s[PN_W-2:0], fb};
  endfunction

  function automatic logic [SIG_W-1:0] misr_next(input logic [SIG_W-1:0] m,
                                                 input logic [DATA_W-1:0] d);
    logic [SIG_W-1:0] sh;
    sh = {m[SIG_W-2:0], 1'b0};
    if (m[SIG_W-1]) sh = sh ^ MISR_POLY;
    return sh ^ SIG_W'(d);
  endfunction
endpackage

// File: rtl/bist_pn_gen.sv
module bist_pn_gen
  import bist_pkg::*;
#(
  parameter int OUT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             load_seed,
  input  logic             step,
  output logic [OUT_W-1:0] word
);
  logic [PN_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         state_q <= PN_SEED;
    else if (hold)      state_q <= PN_SEED;
    else if (load_seed) state_q <= PN_SEED;
    else if (step)      state_q <= lfsr_next(state_q);
  end

  assign word = state_q[PN_W-1 -: OUT_W];

  assert_hold_seed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (state_q == PN_SEED));

  assert_reload_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_seed |=> (state_q == PN_SEED));
endmodule

// File: rtl/bist_run_ctrl.sv
module bist_run_ctrl
  import bist_pkg::*;
#(
  parameter int LEN = RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_start,
  input  logic sel_any,
  output logic start_edge,
  output logic start_ok,
  output logic busy,
  output logic run_last,
  output logic done
);
  localparam int CW = $clog2(LEN);
  localparam logic [CW-1:0] LAST_CNT = CW'(LEN - 1);

  logic          start_q;
  logic [CW-1:0] cnt_q;

  assign start_edge = run_start & ~start_q;
  assign start_ok   = start_edge & ~busy & sel_any;
  assign run_last   = busy & (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= run_start;
      if (start_ok) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        cnt_q <= '0;
      end else if (run_last) begin
        busy  <= 1'b0;
        done  <= 1'b1;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_last |=> (done && !busy));

  assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_midrun_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_edge && !run_last) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));

  assert_no_sel_no_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_edge && !sel_any) |=> !busy);
endmodule

// File: rtl/bist_misr.sv
module bist_misr
  import bist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [SIG_W-1:0]  sig_nxt
);
  logic [SIG_W-1:0] sig_q;

  assign sig_nxt = misr_next(sig_q, din);

  always_ff @(posedge clk) begin
    if (!rst_n)   sig_q <= '0;
    else if (clr) sig_q <= '0;
    else if (en)  sig_q <= sig_nxt;
  end

  assert_clear_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig_q == '0));

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(sig_q));
endmodule

// File: rtl/pn_bist_ctrl.sv
module pn_bist_ctrl
  import bist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        chan_sel,
  input  logic              run_start,
  input  logic              resume_pn,
  input  logic [1:0]        pn_hold,
  input  logic [DATA_W-1:0] adc_a,
  input  logic [DATA_W-1:0] adc_b,
  output logic [DATA_W-1:0] path_out_a,
  output logic [DATA_W-1:0] path_out_b,
  input  logic [DATA_W-1:0] ret_a,
  input  logic [DATA_W-1:0] ret_b,
  output logic [7:0]        sig_lo,
  output logic [7:0]        sig_hi,
  output logic              done
);
  localparam int CH = CHANNELS;

  logic              start_edge, start_ok, busy, run_last;
  logic [CH-1:0]     sel_q;
  logic [CH-1:0]     ch_active;
  logic [SIG_W-1:0]  sig_q;
  logic [DATA_W-1:0] adc_in   [CH];
  logic [DATA_W-1:0] ret_in   [CH];
  logic [DATA_W-1:0] pn_word  [CH];
  logic [DATA_W-1:0] data_out [CH];
  logic [SIG_W-1:0]  misr_nxt [CH];
  logic              load_seed;
  logic [SIG_W-1:0]  pick_sig;

  assign adc_in[0] = adc_a;
  assign adc_in[1] = adc_b;
  assign ret_in[0] = ret_a;
  assign ret_in[1] = ret_b;
  assign path_out_a = data_out[0];
  assign path_out_b = data_out[1];

  bist_run_ctrl #(.LEN(RUN_LEN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_start  (run_start),
    .sel_any    (|chan_sel),
    .start_edge (start_edge),
    .start_ok   (start_ok),
    .busy       (busy),
    .run_last   (run_last),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        sel_q <= '0;
    else if (start_ok) sel_q <= chan_sel;
  end

  assign load_seed = start_ok & ~resume_pn;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    assign ch_active[i] = busy & sel_q[i];

    bist_pn_gen #(.OUT_W(DATA_W)) u_pn (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (pn_hold[i]),
      .load_seed (load_seed),
      .step      (ch_active[i]),
      .word      (pn_word[i])
    );

    bist_misr u_misr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_ok),
      .en      (ch_active[i]),
      .din     (ret_in[i]),
      .sig_nxt (misr_nxt[i])
    );

    assign data_out[i] = ch_active[i] ? pn_word[i] : adc_in[i];
  end

  assign pick_sig = sel_q[0] ? misr_nxt[0] : misr_nxt[1];

  always_ff @(posedge clk) begin
    if (!rst_n)        sig_q <= '0;
    else if (run_last) sig_q <= pick_sig;
  end

  assign sig_lo = sig_q[7:0];
  assign sig_hi = sig_q[15:8];

  assert_sig_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_last |=> $stable(sig_q));

  assert_sig_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_q != $past(sig_q)) |-> $rose(done));

  assert_idle_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (path_out_a == adc_a && path_out_b == adc_b));
endmodule

// File: tb/tb_pn_bist_ctrl.sv
module tb_pn_bist_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [22:0] SEED = 23'h7FFFFF;
  localparam logic [13:0] ADC_A = 14'h1234;
  localparam logic [13:0] ADC_B = 14'h0ABC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] chan_sel = 2'b00;
  logic run_start = 1'b0;
  logic resume_pn = 1'b0;
  logic [1:0] pn_hold = 2'b00;
  logic [13:0] adc_a = ADC_A, adc_b = ADC_B;
  logic [13:0] path_out_a, path_out_b, ret_a, ret_b;
  logic [7:0] sig_lo, sig_hi;
  logic done;

  int n_tests = 0;
  int n_fail = 0;

  logic [27:0] exp_q[$];
  bit started = 0;
  logic [15:0] sig_prev = 16'h0;
  logic [22:0] ma = SEED, mb = SEED;

  always #(CLK_PERIOD/2) clk = ~clk;

  // loopback through the digital path: different transform per channel
  assign ret_a = path_out_a ^ 14'h0A5A;
  assign ret_b = {path_out_b[0], path_out_b[13:1]};

  pn_bist_ctrl dut (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .run_start(run_start),
    .resume_pn(resume_pn), .pn_hold(pn_hold), .adc_a(adc_a), .adc_b(adc_b),
    .path_out_a(path_out_a), .path_out_b(path_out_b), .ret_a(ret_a), .ret_b(ret_b),
    .sig_lo(sig_lo), .sig_hi(sig_hi), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [22:0] m_pn(input logic [22:0] s);
    logic [22:0] r;
    r = s << 1;
    r[0] = s[22] ^ s[17];
    return r;
  endfunction

  function automatic logic [15:0] m_sig(input logic [15:0] m, input logic [13:0] d);
    logic [15:0] r;
    r = {m[14:0], 1'b0} ^ {2'b00, d};
    if (m[15]) r = r ^ 16'h1021;
    return r;
  endfunction

  // monitor: pops expected words while a run is in progress
  always @(negedge clk) begin
    if (started && exp_q.size() > 0) begin
      logic [27:0] e;
      e = exp_q.pop_front();
      chk("R2/R3 word A", {18'h0, path_out_a}, {18'h0, e[27:14]});
      chk("R2/R3 word B", {18'h0, path_out_b}, {18'h0, e[13:0]});
      chk("R4 done low during run", {31'h0, done}, 32'h0);
      chk("R10 signature held during run", {16'h0, sig_hi, sig_lo}, {16'h0, sig_prev});
      if (exp_q.size() == 0) started = 0;
    end
  end

  task automatic do_run(input logic [1:0] sel, input bit resume, input bit hold_a,
                        input bit midstart);
    logic [15:0] sa, sb, exp_sig;
    logic [13:0] wa, wb;
    if (!resume) begin ma = SEED; mb = SEED; end
    if (hold_a) ma = SEED;
    sa = 16'h0; sb = 16'h0;
    for (int k = 0; k < 512; k++) begin
      wa = sel[0] ? ma[22:9] : ADC_A;
      wb = sel[1] ? mb[22:9] : ADC_B;
      exp_q.push_back({wa, wb});
      if (sel[0]) begin
        sa = m_sig(sa, wa ^ 14'h0A5A);
        ma = hold_a ? SEED : m_pn(ma);
      end
      if (sel[1]) begin
        sb = m_sig(sb, {wb[0], wb[13:1]});
        mb = m_pn(mb);
      end
    end
    exp_sig = (sel == 2'b10) ? sb : sa;
    @(negedge clk);
    pn_hold = {1'b0, hold_a};
    chan_sel = sel;
    resume_pn = resume;
    run_start = 1'b1;
    @(posedge clk);
    #1 started = 1;
    if (midstart) begin
      repeat (150) @(negedge clk);
      run_start = 1'b0;   // R9: second edge mid-run
      chan_sel = 2'b11;
      @(negedge clk);
      run_start = 1'b1;
    end
    while (exp_q.size() != 0) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    chk("R4 done after 512 words", {31'h0, done}, 32'h1);
    chk("R5/R6 signature", {16'h0, sig_hi, sig_lo}, {16'h0, exp_sig});
    chk("R3 passthru A after run", {18'h0, path_out_a}, {18'h0, ADC_A});
    chk("R3 passthru B after run", {18'h0, path_out_b}, {18'h0, ADC_B});
    run_start = 1'b0;
    pn_hold = 2'b00;
    sig_prev = exp_sig;
    repeat (3) @(negedge clk);
    chk("R4 done stays high", {31'h0, done}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R4 watchdog expired: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", {31'h0, done}, 32'h0);
    chk("R1 sig after reset", {16'h0, sig_hi, sig_lo}, 32'h0);
    chk("R1 passthru A", {18'h0, path_out_a}, {18'h0, ADC_A});
    chk("R1 passthru B", {18'h0, path_out_b}, {18'h0, ADC_B});

    do_run(2'b01, 1'b0, 1'b0, 1'b0);  // R2 A alone from seed, R6
    do_run(2'b10, 1'b0, 1'b0, 1'b0);  // R6 B alone
    do_run(2'b11, 1'b1, 1'b0, 1'b1);  // R7 resume, R9 mid-run start, R6 both -> A
    do_run(2'b11, 1'b1, 1'b0, 1'b0);  // R7 continue again
    do_run(2'b01, 1'b0, 1'b1, 1'b0);  // R8 hold A at seed

    // R9: start with no channel selected is ignored
    @(negedge clk);
    chan_sel = 2'b00;
    run_start = 1'b1;
    repeat (5) @(negedge clk);
    run_start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 no-sel start keeps done", {31'h0, done}, 32'h1);
    chk("R9 no-sel start keeps sig", {16'h0, sig_hi, sig_lo}, {16'h0, sig_prev});
    chk("R9 no-sel passthru A", {18'h0, path_out_a}, {18'h0, ADC_A});

    do_run(2'b10, 1'b1, 1'b0, 1'b0);  // R7 B continues across unselected runs

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule